// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is a single transmit channel that follows a chain of buffer descriptors kept in a word-addressed memory and turns the buffers they point at into a byte stream. Each descriptor occupies four consecutive words. Software builds the chain and marks every descriptor as owned by the hardware. It then hands the chain over by writing the address of the first descriptor into the head register. For each descriptor the channel fetches the four words and streams the buffer bytes out. Once the final byte has been taken downstream, it writes the mode word back with the ownership flag cleared.

A descriptor whose next pointer is zero is the tail of the queue. Retiring it marks it with an end-of-queue flag, clears the head register and parks the channel. Software that appended work after the channel had already parked sees that flag and writes the head register again. A completion register holds the address of the last descriptor software has reclaimed. A control register gates the channel, and a write-only reset bit aborts it.

Top module: `txdesc_dma`

## Requirements
- R1: After reset `tx_valid` and `mem_req` are low, and all four registers (0 control, 1 head, 2 completion, 3 reset) read zero.
- R2: A write to the head register while the channel is idle stores the value. When the value is nonzero and the control bit 0 (enable) is 1, the channel starts at that descriptor and reads its words at offsets 0 (next pointer), 1 (buffer pointer), 2 (buffer length) and 3 (mode).
- R3: The buffer byte count is taken from bits 10:0 of the length word. Bytes are taken from consecutive words starting at the buffer pointer, four per word, lowest byte lane first, and are emitted in that order.
- R4: `tx_last` is high only on the final byte of a descriptor whose mode bit 30 (end of packet) is set. Descriptors without that bit continue the same packet into the next descriptor.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R6: Only after the last byte of a descriptor has been accepted does the channel write the descriptor's mode word at offset 3. The written word has bit 29 (owner) cleared and every other bit kept, and bit 28 (end of queue) is set exactly when the next pointer is zero.
- R7: After the channel retires a descriptor whose next pointer is zero, the head register reads 0 and the channel issues no further memory requests.
- R8: A descriptor fetched with bit 29 clear is neither streamed nor written back. The head register becomes 0 and the channel stops.
- R9: After an end-of-queue stop, a descriptor linked behind the tail is not fetched until software writes the head register again. After that write it is transmitted.
- R10: With enable 0 a head write does not start the channel. Clearing enable mid-chain lets the current descriptor finish and retire. The channel then stops with the head register holding the next pointer, and setting enable again resumes from there.
- R11: A head register write while the channel is busy is ignored.
- R12: The completion register reads back the last value written to it.
- R13: Writing 1 to bit 0 of the reset register aborts the channel at once, so `tx_valid` is low in the next cycle. It clears the head and completion registers, and the reset register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 head, 2 completion, 3 reset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of a packet |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The streaming path is driven with random chains of one- to three-descriptor packets of random length, under a sink whose readiness is random. This separates correct lane ordering, word stepping at lengths not divisible by four, and end-of-packet placement across descriptor boundaries from stalls caused by backpressure. Directed cases cover a single short packet, a tail extended after parking, a descriptor not owned by hardware, and enable withdrawn while a byte is stalled. In each of these the write-back word, the head readback and the absence of stray bytes show whether the ownership and end-of-queue rules were followed. A reset issued in mid-stream separates an abort from an orderly finish.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned LEN_W    = 11;
   localparam int unsigned MODE_EOP = 30;
   localparam int unsigned MODE_OWN = 29;
   localparam int unsigned MODE_EOQ = 28;

   localparam logic [1:0] RA_CTRL  = 2'd0;
   localparam logic [1:0] RA_HEAD  = 2'd1;
   localparam logic [1:0] RA_DONE  = 2'd2;
   localparam logic [1:0] RA_RESET = 2'd3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DRD,
      ST_DCAP,
      ST_CHECK,
      ST_WRD,
      ST_WCAP,
      ST_SEND,
      ST_WB
   } walk_st_e;

   // Mode word handed back to software once a descriptor is finished.
   function automatic logic [WORD_W-1:0] retire_mode(input logic [WORD_W-1:0] m,
                                                      input logic tail);
      logic [WORD_W-1:0] r;
      r = m;
      r[MODE_OWN] = 1'b0;
      if (tail) r[MODE_EOQ] = 1'b1;
      return r;
   endfunction

endpackage

// File: rtl/txdma_lane_pick.sv
module txdma_lane_pick #(
   parameter int unsigned WORD_W    = 32,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic [WORD_W-1:0]              word,
   input  logic [$clog2(WORD_W/8)-1:0]    sel,
   output logic [7:0]                     byte_o
);
   localparam int unsigned LANES = WORD_W / 8;

   generate
      if (LANES < 2 || (WORD_W % 8) != 0) begin : g_bad_word
         $error("txdma_lane_pick: WORD_W must be a multiple of 8 with at least two lanes");
      end
      if (LSB_FIRST) begin : g_lsb
         assign byte_o = word[sel*8 +: 8];
      end else begin : g_msb
         assign byte_o = word[(LANES-1-sel)*8 +: 8];
      end
   endgenerate
endmodule

// File: rtl/txdma_regs.sv
module txdma_regs
   import txdma_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   input  logic              eng_busy,
   input  logic              eng_head_we,
   input  logic [ADDR_W-1:0] eng_head_val,
   output logic              enable,
   output logic [ADDR_W-1:0] head,
   output logic              srst
);
   logic [ADDR_W-1:0] done_q;
   logic              wr_ctrl;
   logic              wr_head;
   logic              wr_done;
   logic              unused_wdata;

   assign wr_ctrl      = reg_wr && (reg_addr == RA_CTRL);
   assign wr_head      = reg_wr && (reg_addr == RA_HEAD) && !eng_busy;
   assign wr_done      = reg_wr && (reg_addr == RA_DONE);
   assign srst         = reg_wr && (reg_addr == RA_RESET) && reg_wdata[0];
   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable <= 1'b0;
         head   <= '0;
         done_q <= '0;
      end else begin
         if (wr_ctrl) enable <= reg_wdata[0];
         if (srst) begin
            head   <= '0;
            done_q <= '0;
         end else begin
            if (eng_head_we)  head <= eng_head_val;
            else if (wr_head) head <= reg_wdata[ADDR_W-1:0];
            if (wr_done) done_q <= reg_wdata[ADDR_W-1:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CTRL: reg_rdata[0]          = enable;
         RA_HEAD: reg_rdata[ADDR_W-1:0] = head;
         RA_DONE: reg_rdata[ADDR_W-1:0] = done_q;
         default: reg_rdata             = '0;
      endcase
   end
endmodule

// File: rtl/txdma_walker.sv
module txdma_walker
   import txdma_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              enable,
   input  logic [ADDR_W-1:0] head,
   output logic              busy,
   output logic              head_we,
   output logic [ADDR_W-1:0] head_val,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   output logic              tx_last,
   input  logic              tx_ready
);
   localparam int unsigned LANES  = WORD_W / 8;
   localparam int unsigned LANE_W = $clog2(LANES);
   localparam logic [LANE_W-1:0] LANE_TOP = LANE_W'(LANES - 1);

   walk_st_e           st;
   logic [ADDR_W-1:0]  cur;
   logic [1:0]         idx;
   logic [ADDR_W-1:0]  nxt_p;
   logic [ADDR_W-1:0]  buf_p;
   logic [LEN_W-1:0]   blen;
   logic [WORD_W-1:0]  mode;
   logic [ADDR_W-1:0]  wptr;
   logic [LEN_W-1:0]   left;
   logic [LANE_W-1:0]  lane;
   logic [WORD_W-1:0]  word;
   logic               start;
   logic               tail;

   assign start = (st == ST_IDLE) && enable && (head != '0);
   assign busy  = (st != ST_IDLE) || start;
   assign tail  = (nxt_p == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cur   <= '0;
         idx   <= '0;
         nxt_p <= '0;
         buf_p <= '0;
         blen  <= '0;
         mode  <= '0;
         wptr  <= '0;
         left  <= '0;
         lane  <= '0;
         word  <= '0;
      end else if (srst) begin
         st <= ST_IDLE;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  cur <= head;
                  idx <= '0;
                  st  <= ST_DRD;
               end
            end
            ST_DRD: st <= ST_DCAP;
            ST_DCAP: begin
               unique case (idx)
                  2'd0:    nxt_p <= mem_rdata[ADDR_W-1:0];
                  2'd1:    buf_p <= mem_rdata[ADDR_W-1:0];
                  2'd2:    blen  <= mem_rdata[LEN_W-1:0];
                  default: mode  <= mem_rdata;
               endcase
               idx <= idx + 2'd1;
               st  <= (idx == 2'd3) ? ST_CHECK : ST_DRD;
            end
            ST_CHECK: begin
               if (!mode[MODE_OWN]) begin
                  st <= ST_IDLE;
               end else begin
                  wptr <= buf_p;
                  left <= blen;
                  lane <= '0;
                  st   <= (blen == '0) ? ST_WB : ST_WRD;
               end
            end
            ST_WRD: st <= ST_WCAP;
            ST_WCAP: begin
               word <= mem_rdata;
               st   <= ST_SEND;
            end
            ST_SEND: begin
               if (tx_ready) begin
                  left <= left - LEN_W'(1);
                  lane <= lane + LANE_W'(1);
                  if (left == LEN_W'(1)) begin
                     st <= ST_WB;
                  end else if (lane == LANE_TOP) begin
                     wptr <= wptr + ADDR_W'(1);
                     st   <= ST_WRD;
                  end
               end
            end
            ST_WB: begin
               if (tail || !enable) begin
                  st <= ST_IDLE;
               end else begin
                  cur <= nxt_p;
                  idx <= '0;
                  st  <= ST_DRD;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      head_we  = 1'b0;
      head_val = '0;
      if (st == ST_CHECK && !mode[MODE_OWN]) begin
         head_we = 1'b1;
      end else if (st == ST_WB) begin
         head_we  = 1'b1;
         head_val = nxt_p;
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st)
         ST_DRD: begin
            mem_req  = 1'b1;
            mem_addr = cur + ADDR_W'(idx);
         end
         ST_WRD: begin
            mem_req  = 1'b1;
            mem_addr = wptr;
         end
         ST_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur + ADDR_W'(3);
            mem_wdata = retire_mode(mode, tail);
         end
         default: ;
      endcase
   end

   txdma_lane_pick #(
      .WORD_W    (WORD_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_lane (
      .word   (word),
      .sel    (lane),
      .byte_o (tx_data)
   );

   assign tx_valid = (st == ST_SEND);
   assign tx_last  = (st == ST_SEND) && mode[MODE_EOP] && (left == LEN_W'(1));
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
   import txdma_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   output logic              tx_last,
   input  logic              tx_ready
);
   generate
      if (ADDR_W < 4 || ADDR_W > WORD_W) begin : g_bad_addr
         $error("txdesc_dma: ADDR_W must lie between 4 and the word width");
      end
   endgenerate

   logic              enable;
   logic [ADDR_W-1:0] head;
   logic              srst;
   logic              busy;
   logic              head_we;
   logic [ADDR_W-1:0] head_val;

   txdma_regs #(
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr       (reg_wr),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .eng_busy     (busy),
      .eng_head_we  (head_we),
      .eng_head_val (head_val),
      .enable       (enable),
      .head         (head),
      .srst         (srst)
   );

   txdma_walker #(
      .ADDR_W    (ADDR_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst      (srst),
      .enable    (enable),
      .head      (head),
      .busy      (busy),
      .head_we   (head_we),
      .head_val  (head_val),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .tx_last   (tx_last),
      .tx_ready  (tx_ready)
   );
endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        tx_data,
   input logic              tx_valid,
   input logic              tx_last,
   input logic              tx_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic              wb_own,
   input logic              busy,
   input logic              enable,
   input logic [ADDR_W-1:0] head,
   input logic              srst
);
   // R5: a stalled byte is held
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !srst) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   // R4: last only flags a presented byte
   p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   // R6: write-back returns ownership and never overlaps a pending byte
   p_wb_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !wb_own);
   p_wb_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_req && !tx_valid));

   // R7: a parked channel with an empty head stays off the memory
   p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && head == '0) |-> !mem_req);

   // R10: disabled and idle means no memory traffic
   p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !busy) |-> !mem_req);

   // R13: the reset bit aborts the channel in one cycle
   p_srst_r13: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (!tx_valid && head == '0 && !busy));
endmodule

bind txdesc_dma txdesc_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_data  (tx_data),
   .tx_valid (tx_valid),
   .tx_last  (tx_last),
   .tx_ready (tx_ready),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .wb_own   (mem_wdata[29]),
   .busy     (busy),
   .enable   (enable),
   .head     (head),
   .srst     (srst)
);

// File: tb/txdesc_dma_bench.sv
module txdesc_dma_bench;
   localparam int AW = 10;
   localparam logic [31:0] F_SOP = 32'h8000_0000;
   localparam logic [31:0] F_EOP = 32'h4000_0000;
   localparam logic [31:0] F_OWN = 32'h2000_0000;
   localparam logic [31:0] F_EOQ = 32'h1000_0000;
   localparam logic [1:0] A_CTRL = 2'd0, A_HEAD = 2'd1, A_DONE = 2'd2, A_RST = 2'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic [7:0] tx_data;
   logic tx_valid, tx_last;
   logic tx_ready = 1'b0;

   logic [31:0] mem [1024];
   logic [7:0] got_d[$], exp_d[$];
   bit got_l[$], exp_l[$];
   int n_chk = 0, n_err = 0, cyc = 0, rdy_pct = 100;
   int next_desc = 16, next_buf = 256;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   txdesc_dma #(.ADDR_W(AW)) u_txdesc_dma (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_last(tx_last), .tx_ready(tx_ready)
   );

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr];
      end
   end

   // Sink: choose readiness, then record the handshake of the coming edge
   always @(negedge clk) begin
      tx_ready = (($urandom % 100) < rdy_pct);
      #1;
      if (tx_valid && tx_ready) begin
         got_d.push_back(tx_data);
         got_l.push_back(tx_last);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #2 d = reg_rdata;
   endtask

   function automatic int alloc_desc();
      alloc_desc = next_desc; next_desc += 4;
   endfunction

   function automatic int alloc_buf();
      alloc_buf = next_buf; next_buf += 8;
   endfunction

   function automatic logic [31:0] exp_wb(input logic [31:0] m, input bit tail);
      exp_wb = (m & ~F_OWN) | (tail ? F_EOQ : 32'h0);
   endfunction

   task automatic put_desc(input int a, input int nx, input int bp, input int len, input logic [31:0] fl);
      mem[a] = 32'(nx); mem[a+1] = 32'(bp); mem[a+2] = 32'(len); mem[a+3] = fl | 32'(len);
   endtask

   // Little-endian packing, four bytes per word, expected stream appended
   task automatic put_bytes(input int bp, input int n, input bit eop);
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         b = 8'($urandom);
         mem[bp + i/4][8*(i%4) +: 8] = b;
         exp_d.push_back(b);
         exp_l.push_back(eop && (i == n-1));
      end
   endtask

   task automatic clear_stream();
      got_d.delete(); got_l.delete(); exp_d.delete(); exp_l.delete();
   endtask

   task automatic cmp_stream(input string req);
      chk(req, "byte count", 32'(got_d.size()), 32'(exp_d.size()));
      for (int i = 0; i < exp_d.size() && i < got_d.size(); i++) begin
         chk(req, "byte", 32'(got_d[i]), 32'(exp_d[i]));
         chk("R4", "last flag", 32'(got_l[i]), 32'(exp_l[i]));
      end
   endtask

   task automatic wait_idle(input int maxc);
      logic [31:0] h;
      int c = 0;
      do begin reg_read(A_HEAD, h); c++; end while (h != 0 && c < maxc);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      logic [31:0] r;
      int da[24], dl[24];
      logic [31:0] df[24];
      int nd, a, b, c, ba, bb, bc;
      void'($urandom(32'h5eed_7a11));
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk); #2;
      chk("R1", "tx_valid", 32'(tx_valid), 0);
      chk("R1", "mem_req", 32'(mem_req), 0);
      for (int k = 0; k < 4; k++) begin
         reg_read(2'(k), r);
         chk("R1", "register", r, 0);
      end

      reg_write(A_CTRL, 1);

      // R2 R3 R6 R7: single short packet, length not a multiple of four
      clear_stream();
      a = alloc_desc(); ba = alloc_buf();
      put_desc(a, 0, ba, 5, F_OWN | F_SOP | F_EOP); put_bytes(ba, 5, 1'b1);
      reg_write(A_HEAD, 32'(a));
      wait_idle(2000);
      cmp_stream("R3");
      chk("R6", "single write-back", mem[a+3], exp_wb(F_OWN | F_SOP | F_EOP | 5, 1'b1));
      reg_read(A_HEAD, r);
      chk("R7", "head after tail", r, 0);

      // R9: link behind the parked tail; nothing happens until head is rewritten
      clear_stream();
      b = alloc_desc(); bb = alloc_buf();
      put_desc(b, 0, bb, 9, F_OWN | F_SOP | F_EOP); put_bytes(bb, 9, 1'b1);
      mem[a] = 32'(b);
      repeat (30) @(negedge clk);
      chk("R9", "bytes before head write", 32'(got_d.size()), 0);
      reg_write(A_HEAD, 32'(b));
      wait_idle(2000);
      cmp_stream("R9");
      chk("R9", "restart write-back", mem[b+3], exp_wb(F_OWN | F_SOP | F_EOP | 9, 1'b1));

      // R3 R4 R6: random multi-descriptor chain with random backpressure
      clear_stream();
      rdy_pct = 60;
      nd = 0;
      for (int p = 0; p < 6; p++) begin
         int parts;
         parts = 1 + int'($urandom % 3);
         for (int q = 0; q < parts; q++) begin
            da[nd] = alloc_desc();
            dl[nd] = 1 + int'($urandom % 24);
            df[nd] = F_OWN | ((q == 0) ? F_SOP : 32'h0) | ((q == parts-1) ? F_EOP : 32'h0);
            nd++;
         end
      end
      for (int k = 0; k < nd; k++) begin
         int bp;
         bp = alloc_buf();
         put_desc(da[k], (k == nd-1) ? 0 : da[k+1], bp, dl[k], df[k]);
         put_bytes(bp, dl[k], df[k][30]);
      end
      reg_write(A_HEAD, 32'(da[0]));
      wait_idle(20000);
      cmp_stream("R3");
      for (int k = 0; k < nd; k++)
         chk("R6", "chain write-back", mem[da[k]+3], exp_wb(df[k] | 32'(dl[k]), k == nd-1));
      rdy_pct = 100;

      // R8: descriptor not owned by hardware
      clear_stream();
      c = alloc_desc(); bc = alloc_buf();
      put_desc(c, 0, bc, 4, F_SOP | F_EOP);
      reg_write(A_HEAD, 32'(c));
      repeat (40) @(negedge clk);
      reg_read(A_HEAD, r);
      chk("R8", "head after unowned", r, 0);
      chk("R8", "bytes from unowned", 32'(got_d.size()), 0);
      chk("R8", "unowned mode untouched", mem[c+3], F_SOP | F_EOP | 4);

      // R10 R11: enable gating and busy head writes
      clear_stream();
      reg_write(A_CTRL, 0);
      a = alloc_desc(); b = alloc_desc(); ba = alloc_buf(); bb = alloc_buf();
      put_desc(a, b, ba, 6, F_OWN | F_SOP); put_bytes(ba, 6, 1'b0);
      put_desc(b, 0, bb, 7, F_OWN | F_EOP); put_bytes(bb, 7, 1'b1);
      rdy_pct = 0;
      reg_write(A_HEAD, 32'(a));
      repeat (30) @(negedge clk);
      chk("R10", "bytes while disabled", 32'(got_d.size()), 0);
      chk("R10", "mode while disabled", mem[a+3], F_OWN | F_SOP | 6);
      reg_read(A_HEAD, r);
      chk("R10", "head stored while disabled", r, 32'(a));
      reg_write(A_CTRL, 1);
      repeat (30) @(negedge clk);
      #2 chk("R10", "stalled byte after enable", 32'(tx_valid), 1);
      reg_write(A_HEAD, 32'(b));
      reg_read(A_HEAD, r);
      chk("R11", "head write while busy", r, 32'(a));
      reg_write(A_CTRL, 0);
      rdy_pct = 100;
      repeat (60) @(negedge clk);
      chk("R10", "bytes after disable", 32'(got_d.size()), 6);
      chk("R10", "first retired", mem[a+3], exp_wb(F_OWN | F_SOP | 6, 1'b0));
      chk("R10", "second untouched", mem[b+3], F_OWN | F_EOP | 7);
      reg_read(A_HEAD, r);
      chk("R10", "head holds next", r, 32'(b));
      reg_write(A_CTRL, 1);
      wait_idle(2000);
      cmp_stream("R10");
      chk("R10", "second retired", mem[b+3], exp_wb(F_OWN | F_EOP | 7, 1'b1));

      // R12: completion register readback
      reg_write(A_DONE, 32'h155);
      reg_read(A_DONE, r);
      chk("R12", "completion readback", r, 32'h155);
      reg_write(A_DONE, 32'h3ff);
      reg_read(A_DONE, r);
      chk("R12", "completion readback top", r, 32'h3ff);

      // R13: abort in mid-stream
      clear_stream();
      c = alloc_desc(); bc = alloc_buf();
      put_desc(c, 0, bc, 30, F_OWN | F_SOP | F_EOP); put_bytes(bc, 30, 1'b1);
      rdy_pct = 0;
      reg_write(A_HEAD, 32'(c));
      repeat (20) @(negedge clk);
      #2 chk("R13", "stalled before abort", 32'(tx_valid), 1);
      reg_write(A_RST, 1);
      #2 chk("R13", "tx_valid after abort", 32'(tx_valid), 0);
      reg_read(A_HEAD, r);
      chk("R13", "head after abort", r, 0);
      reg_read(A_DONE, r);
      chk("R13", "completion after abort", r, 0);
      reg_read(A_RST, r);
      chk("R13", "reset bit reads zero", r, 0);
      rdy_pct = 100;
      repeat (30) @(negedge clk);
      chk("R13", "bytes after abort", 32'(got_d.size()), 0);
      chk("R13", "aborted mode untouched", mem[c+3], F_OWN | F_SOP | F_EOP | 30);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule